// File: doc/BRIEF.md
# Tape Image Playback Serializer

This block plays back a cassette image that a host has placed in a dual-port cache. The cache holds a 128-byte header and a payload area. The block reads the cache one byte at a time through a synchronous read port. It turns the image into a pulse-width coded serial line for an emulated 8-bit CPU. The line carries a leading tone of zero bits, then the header, then a second tone, then the payload. Each byte is sent as a start bit of value 1 followed by its eight data bits, most significant bit first. The payload length is not supplied on a port. The block takes it from a little-endian 16-bit field inside the header as that field streams past.

The host raises a one-cycle load strobe once it has written an image into the cache. The emulated CPU controls the transport through a play command and a reel-motor line. Serialization advances only while both are on and an image is pending. Dropping either one freezes the line at its current bit, and playback later resumes from that point. A 3-bit speed code divides every pulse duration by a power of two, from 1× up to 32×. When the last bit has been sent, the ready flag drops so that the host knows to load the next file.

Top module: `tape_play_serializer`

## Requirements
- R1: While reset is held, and on the first cycle after it, every status output and the serial line are 0.
- R2: One edge after a load strobe, both `image_ready_o` and `loaded_o` read 1. `tape_sense_o` follows `play_btn_i & loaded_o` with one edge of delay.
- R3: `playing_o` equals `image_ready_o & play_btn_i & motor_on_i`, registered one edge later. No pulse appears on `tape_bit_o` while `playing_o` is 0.
- R4: A 1 bit is a high period of LONG_CYC>>k cycles and a 0 bit is a high period of SHORT_CYC>>k cycles, where k is the effective speed shift. Each high period is followed by at least SHORT_CYC>>k low cycles.
- R5: Speed codes 0 to 5 give shifts 0 to 5 (1× to 32×). Codes 6 and 7 act as code 5.
- R6: The bit order is TONE_BITS zeros, then the 128 header bytes, then TONE_BITS zeros, then the payload. Every byte is a start bit 1 followed by bits 7 down to 0.
- R7: The payload length is header byte 18 (low half) combined with header byte 19 (high half). Payload byte i is read from cache address 128+i, and header byte j is read from address j.
- R8: A payload length of 0 ends the image right after the header, with no second tone.
- R9: `image_ready_o` clears only after the low period of the last bit. `loaded_o` stays 1.
- R10: While playback is halted, `tape_bit_o` holds its value. On resume, the stream continues with no bit lost, repeated or changed in width.
- R11: A load strobe given in the middle of an image restarts playback from the first tone bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| image_load_i | input | 1 | One-cycle strobe: a new image is in the cache |
| play_btn_i | input | 1 | Play command from the emulated CPU |
| motor_on_i | input | 1 | Reel motor on |
| speed_sel_i | input | 3 | Speed code, shift = min(code, 5) |
| cache_raddr_o | output | LEN_W+1 | Cache read address (header at 0, payload at 128) |
| cache_rdata_i | input | 8 | Cache read data, valid one cycle after the address |
| tape_bit_o | output | 1 | Pulse-width coded serial line |
| tape_sense_o | output | 1 | Sense line to the CPU |
| image_ready_o | output | 1 | An image is loaded and not yet fully played |
| playing_o | output | 1 | Serialization is advancing |
| loaded_o | output | 1 | An image has been loaded since reset |

## Verification
The status flags are registered. They are compared at the falling edge that follows the single rising edge that samples a load strobe or a change of button or motor. The first high pulse begins on the same edge at which `playing_o` is first seen high. The bench therefore measures every high and low period by counting falling-edge samples taken while `playing_o` is 1. This makes each count equal to the number of edges on which the pulse timer advanced, including across pauses. Completion is checked by waiting for `image_ready_o` to fall, then comparing the recorded pulse list entry by entry against a stream built from R6 to R8.

// File: rtl/tape_play_pkg.sv
package tape_play_pkg;

   localparam int HDR_BYTES   = 128;
   localparam int LEN_LO_OFS  = 18;
   localparam int LEN_HI_OFS  = 19;
   localparam int MAX_SHIFT   = 5;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_TONE_H,
      PH_HDR,
      PH_TONE_D,
      PH_DATA,
      PH_DRAIN
   } phase_e;

   typedef enum logic [1:0] {
      BS_FETCH,
      BS_LATCH,
      BS_SEND
   } byte_st_e;

   typedef enum logic [1:0] {
      PG_IDLE,
      PG_HIGH,
      PG_LOW
   } pulse_st_e;

   function automatic logic [2:0] clamp_speed(input logic [2:0] code);
      return (code > 3'(MAX_SHIFT)) ? 3'(MAX_SHIFT) : code;
   endfunction

endpackage

// File: rtl/tape_pulse_gen.sv
module tape_pulse_gen
   import tape_play_pkg::*;
#(
   parameter int LONG_CYC  = 92800,
   parameter int SHORT_CYC = 48000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic       run_i,
   input  logic       bit_valid_i,
   input  logic       bit_i,
   input  logic [2:0] speed_i,
   output logic       ready_o,
   output logic       pulse_o
);

   localparam int CW = $clog2(LONG_CYC + 1);

   initial begin
      assert (SHORT_CYC >= (1 << MAX_SHIFT))
         else $error("tape_pulse_gen: SHORT_CYC too small for 32x");
      assert (LONG_CYC > SHORT_CYC)
         else $error("tape_pulse_gen: LONG_CYC must exceed SHORT_CYC");
   end

   logic [CW-1:0] long_tab  [0:MAX_SHIFT];
   logic [CW-1:0] short_tab [0:MAX_SHIFT];

   for (genvar g = 0; g <= MAX_SHIFT; g++) begin : g_tab
      assign long_tab[g]  = CW'(LONG_CYC >> g);
      assign short_tab[g] = CW'(SHORT_CYC >> g);
   end

   pulse_st_e     state;
   logic [CW-1:0] cnt;
   logic [2:0]    sh_q;
   logic [2:0]    sh_now;
   logic          pulse_q;

   assign sh_now  = clamp_speed(speed_i);
   assign ready_o = (state == PG_IDLE);
   assign pulse_o = pulse_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         state   <= PG_IDLE;
         cnt     <= '0;
         sh_q    <= '0;
         pulse_q <= 1'b0;
      end else if (run_i) begin
         case (state)
            PG_IDLE: begin
               if (bit_valid_i) begin
                  state   <= PG_HIGH;
                  pulse_q <= 1'b1;
                  sh_q    <= sh_now;
                  cnt     <= bit_i ? long_tab[sh_now] : short_tab[sh_now];
               end
            end
            PG_HIGH: begin
               if (cnt == CW'(1)) begin
                  state   <= PG_LOW;
                  pulse_q <= 1'b0;
                  cnt     <= short_tab[sh_q];
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PG_LOW: begin
               if (cnt == CW'(1)) begin
                  state <= PG_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: state <= PG_IDLE;
         endcase
      end
   end

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !clr_i) |=> $stable(pulse_o));

   // R3
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PG_IDLE && !clr_i && !(run_i && bit_valid_i)) |=> !pulse_o);

endmodule

// File: rtl/tape_frame_seq.sv
module tape_frame_seq
   import tape_play_pkg::*;
#(
   parameter int TONE_BITS = 256,
   parameter int LEN_W     = 16,
   localparam int AW       = LEN_W + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          run_i,
   input  logic          pg_ready_i,
   output logic [AW-1:0] cache_addr_o,
   input  logic [7:0]    cache_data_i,
   output logic          bit_valid_o,
   output logic          bit_o,
   output logic          finished_o
);

   localparam int TW = $clog2(TONE_BITS + 1);

   initial begin
      assert (TONE_BITS >= 1) else $error("tape_frame_seq: TONE_BITS must be at least 1");
      assert (LEN_W >= 8) else $error("tape_frame_seq: LEN_W must be at least 8");
   end

   phase_e           phase;
   byte_st_e         bst;
   logic [LEN_W-1:0] byte_idx;
   logic [LEN_W-1:0] len_q;
   logic [3:0]       bit_cnt;
   logic [TW-1:0]    tone_cnt;
   logic [7:0]       shreg;
   logic             in_tone;
   logic             in_bytes;
   logic             accept;
   logic             last_byte;

   assign in_tone   = (phase == PH_TONE_H) || (phase == PH_TONE_D);
   assign in_bytes  = (phase == PH_HDR) || (phase == PH_DATA);
   assign bit_valid_o = in_tone || (in_bytes && bst == BS_SEND);
   assign bit_o     = in_tone ? 1'b0 : ((bit_cnt == 4'd0) ? 1'b1 : shreg[7]);
   assign accept    = run_i && pg_ready_i && bit_valid_o;
   assign last_byte = (phase == PH_HDR) ? (byte_idx == LEN_W'(HDR_BYTES - 1))
                                        : (byte_idx == len_q - 1'b1);
   assign finished_o = run_i && (phase == PH_DRAIN) && pg_ready_i;
   assign cache_addr_o = (phase == PH_DATA) ? (AW'(HDR_BYTES) + AW'(byte_idx))
                                            : AW'(byte_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         bst      <= BS_FETCH;
         byte_idx <= '0;
         len_q    <= '0;
         bit_cnt  <= '0;
         tone_cnt <= '0;
         shreg    <= '0;
      end else if (start_i) begin
         phase    <= PH_TONE_H;
         bst      <= BS_FETCH;
         byte_idx <= '0;
         len_q    <= '0;
         bit_cnt  <= '0;
         tone_cnt <= '0;
      end else if (run_i) begin
         case (phase)
            PH_TONE_H, PH_TONE_D: begin
               if (accept) begin
                  if (tone_cnt == TW'(TONE_BITS - 1)) begin
                     tone_cnt <= '0;
                     phase    <= (phase == PH_TONE_H) ? PH_HDR : PH_DATA;
                     bst      <= BS_FETCH;
                     byte_idx <= '0;
                  end else begin
                     tone_cnt <= tone_cnt + 1'b1;
                  end
               end
            end
            PH_HDR, PH_DATA: begin
               case (bst)
                  BS_FETCH: bst <= BS_LATCH;
                  BS_LATCH: begin
                     shreg   <= cache_data_i;
                     bit_cnt <= '0;
                     bst     <= BS_SEND;
                     if (phase == PH_HDR && byte_idx == LEN_W'(LEN_LO_OFS))
                        len_q[7:0] <= cache_data_i;
                     if (phase == PH_HDR && byte_idx == LEN_W'(LEN_HI_OFS))
                        len_q[LEN_W-1:8] <= (LEN_W-8)'(cache_data_i);
                  end
                  default: begin
                     if (accept) begin
                        if (bit_cnt != 4'd0)
                           shreg <= {shreg[6:0], 1'b0};
                        if (bit_cnt == 4'd8) begin
                           bst     <= BS_FETCH;
                           bit_cnt <= '0;
                           if (last_byte) begin
                              byte_idx <= '0;
                              if (phase == PH_HDR && len_q != '0)
                                 phase <= PH_TONE_D;
                              else
                                 phase <= PH_DRAIN;
                           end else begin
                              byte_idx <= byte_idx + 1'b1;
                           end
                        end else begin
                           bit_cnt <= bit_cnt + 1'b1;
                        end
                     end
                  end
               endcase
            end
            PH_DRAIN: begin
               if (pg_ready_i)
                  phase <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R8
   data_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA) |-> (len_q != '0));

   // R7
   data_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA && bst == BS_FETCH) |-> (cache_addr_o >= AW'(HDR_BYTES)));

endmodule

// File: rtl/tape_status.sv
module tape_status (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic finished_i,
   input  logic play_btn_i,
   input  logic motor_on_i,
   output logic loaded_o,
   output logic image_ready_o,
   output logic playing_o,
   output logic sense_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loaded_o      <= 1'b0;
         image_ready_o <= 1'b0;
         playing_o     <= 1'b0;
         sense_o       <= 1'b0;
      end else begin
         if (load_i) begin
            loaded_o      <= 1'b1;
            image_ready_o <= 1'b1;
         end else if (finished_i) begin
            image_ready_o <= 1'b0;
         end
         playing_o <= image_ready_o && play_btn_i && motor_on_i;
         sense_o   <= loaded_o && play_btn_i;
      end
   end

   // R2
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (image_ready_o && loaded_o));

   // R9
   ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (finished_i && !load_i) |=> (!image_ready_o && loaded_o));

   // R3
   playing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      playing_o |-> loaded_o);

endmodule

// File: rtl/tape_play_serializer.sv
module tape_play_serializer
   import tape_play_pkg::*;
#(
   parameter int LONG_CYC  = 92800,
   parameter int SHORT_CYC = 48000,
   parameter int TONE_BITS = 256,
   parameter int LEN_W     = 16,
   localparam int AW       = LEN_W + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          image_load_i,
   input  logic          play_btn_i,
   input  logic          motor_on_i,
   input  logic [2:0]    speed_sel_i,
   output logic [AW-1:0] cache_raddr_o,
   input  logic [7:0]    cache_rdata_i,
   output logic          tape_bit_o,
   output logic          tape_sense_o,
   output logic          image_ready_o,
   output logic          playing_o,
   output logic          loaded_o
);

   logic run;
   logic pg_ready;
   logic bit_valid;
   logic bit_val;
   logic finished;

   assign run = playing_o;

   tape_frame_seq #(
      .TONE_BITS (TONE_BITS),
      .LEN_W     (LEN_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (image_load_i),
      .run_i        (run),
      .pg_ready_i   (pg_ready),
      .cache_addr_o (cache_raddr_o),
      .cache_data_i (cache_rdata_i),
      .bit_valid_o  (bit_valid),
      .bit_o        (bit_val),
      .finished_o   (finished)
   );

   tape_pulse_gen #(
      .LONG_CYC  (LONG_CYC),
      .SHORT_CYC (SHORT_CYC)
   ) u_pulse (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (image_load_i),
      .run_i       (run),
      .bit_valid_i (bit_valid),
      .bit_i       (bit_val),
      .speed_i     (speed_sel_i),
      .ready_o     (pg_ready),
      .pulse_o     (tape_bit_o)
   );

   tape_status u_status (
      .clk           (clk),
      .rst_n         (rst_n),
      .load_i        (image_load_i),
      .finished_i    (finished),
      .play_btn_i    (play_btn_i),
      .motor_on_i    (motor_on_i),
      .loaded_o      (loaded_o),
      .image_ready_o (image_ready_o),
      .playing_o     (playing_o),
      .sense_o       (tape_sense_o)
   );

   // R3
   no_pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!playing_o && !tape_bit_o) |=> !tape_bit_o);

endmodule

// File: tb/tape_play_serializer_tb.sv
`timescale 1ns/1ps
module tape_play_serializer_tb;

   localparam int LONG  = 64;
   localparam int SHORT = 32;
   localparam int TONE  = 4;
   localparam int MAXB  = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic        play = 1'b0;
   logic        motor = 1'b0;
   logic [2:0]  spd = 3'd0;
   logic [16:0] raddr;
   logic [7:0]  rdata;
   logic        tape_bit, sense, image_ready, playing, loaded;

   logic [7:0] mem [0:1023];

   always #2.5 clk = ~clk;
   always @(posedge clk) rdata <= mem[raddr[9:0]];

   tape_play_serializer #(
      .LONG_CYC (LONG), .SHORT_CYC (SHORT), .TONE_BITS (TONE), .LEN_W (16)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .image_load_i (load), .play_btn_i (play),
      .motor_on_i (motor), .speed_sel_i (spd), .cache_raddr_o (raddr),
      .cache_rdata_i (rdata), .tape_bit_o (tape_bit), .tape_sense_o (sense),
      .image_ready_o (image_ready), .playing_o (playing), .loaded_o (loaded)
   );

   int checks = 0;
   int errors = 0;

   // pulse monitor
   int got_w [0:MAXB-1];
   int got_n, hi_cnt, lo_cnt, min_lo;
   bit prev_hi, rdy_last, clr_req = 1'b0;

   always @(negedge clk) begin
      if (clr_req) begin
         got_n = 0; hi_cnt = 0; lo_cnt = 0; min_lo = 1 << 30; prev_hi = 1'b0;
      end else begin
         if (tape_bit) begin
            if (!prev_hi) begin
               if (got_n > 0 && lo_cnt < min_lo) min_lo = lo_cnt;
               lo_cnt = 0;
            end
            if (playing) hi_cnt++;
         end else begin
            if (prev_hi && hi_cnt > 0) begin
               if (got_n < MAXB) got_w[got_n] = hi_cnt;
               got_n++;
               hi_cnt = 0;
               lo_cnt = 0;
               rdy_last = image_ready;
            end
            if (playing) lo_cnt++;
         end
         prev_hi = tape_bit;
      end
   end

   bit exp_b [0:MAXB-1];
   int exp_n;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic int eff(input int s);
      return (s > 5) ? 5 : s;
   endfunction

   task automatic push_byte(input logic [7:0] b);
      exp_b[exp_n] = 1'b1; exp_n++;
      for (int i = 7; i >= 0; i--) begin
         exp_b[exp_n] = b[i]; exp_n++;
      end
   endtask

   task automatic build_image(input int len, input int seed);
      exp_n = 0;
      for (int k = 0; k < 1024; k++) mem[k] = 8'h00;
      for (int k = 0; k < 128; k++) mem[k] = 8'((k * 37 + seed * 13 + 5) & 255);
      mem[0]  = 8'hA5;
      mem[18] = 8'(len & 255);
      mem[19] = 8'((len >> 8) & 255);
      for (int i = 0; i < len; i++) mem[128 + i] = 8'((i * 11 + seed * 3 + 1) & 255);
      for (int t = 0; t < TONE; t++) begin exp_b[exp_n] = 1'b0; exp_n++; end
      for (int k = 0; k < 128; k++) push_byte(mem[k]);
      if (len > 0) begin
         for (int t = 0; t < TONE; t++) begin exp_b[exp_n] = 1'b0; exp_n++; end
         for (int i = 0; i < len; i++) push_byte(mem[128 + i]);
      end
   endtask

   task automatic pulse_load();
      @(posedge clk); #1 load = 1'b1;
      @(posedge clk); #1 load = 1'b0;
      clr_req = 1'b1;
      @(negedge clk); @(negedge clk);
      #1 clr_req = 1'b0;
   endtask

   task automatic start_run(input int s);
      play = 1'b0; motor = 1'b0;
      pulse_load();
      @(posedge clk); #1 spd = 3'(s); play = 1'b1; motor = 1'b1;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (image_ready && n < 60000) begin @(posedge clk); n++; end
      @(negedge clk);
      check(!image_ready, req, "image_ready cleared at end", int'(image_ready), 0);
   endtask

   task automatic compare(input int s, input int n_cmp, input string req);
      int mism = 0, fa = 0, fe = 0;
      for (int i = 0; i < n_cmp && i < got_n && i < MAXB; i++) begin
         int we = (exp_b[i] ? LONG : SHORT) >> eff(s);
         if (got_w[i] != we) begin
            if (mism == 0) begin fa = got_w[i]; fe = we; end
            mism++;
         end
      end
      check(mism == 0, req, "high widths / bit values (first mismatch)", fa, fe);
      check(min_lo >= (SHORT >> eff(s)), req, "minimum low period", min_lo, SHORT >> eff(s));
   endtask

   task automatic t_reset();
      @(negedge clk);
      check({tape_bit, sense, image_ready, playing, loaded} == 5'b0, "R1",
            "outputs during reset", int'({tape_bit, sense, image_ready, playing, loaded}), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check({tape_bit, sense, image_ready, playing, loaded} == 5'b0, "R1",
            "outputs after reset", int'({tape_bit, sense, image_ready, playing, loaded}), 0);
   endtask

   task automatic t_gate();
      build_image(3, 1);
      @(posedge clk); #1 play = 1'b1; motor = 1'b0;
      @(posedge clk); #1 load = 1'b1;
      @(posedge clk); #1 load = 1'b0;
      @(negedge clk);
      check(image_ready && loaded, "R2", "flags one edge after load",
            int'({image_ready, loaded}), 3);
      @(negedge clk);
      check(sense, "R2", "sense with play pressed", int'(sense), 1);
      clr_req = 1'b1; @(negedge clk); @(negedge clk); #1 clr_req = 1'b0;
      repeat (50) @(posedge clk);
      @(negedge clk);
      check(!playing && !tape_bit && got_n == 0, "R3", "no playback with motor off",
            got_n, 0);
      @(posedge clk); #1 motor = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(playing, "R3", "playing one edge after motor on", int'(playing), 1);
      @(posedge clk); #1 play = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check(!sense && !playing, "R3", "sense/playing drop after play release",
            int'({sense, playing}), 0);
   endtask

   task automatic t_speeds();
      build_image(3, 4);
      for (int s = 0; s < 8; s++) begin
         int n = 0;
         start_run(s);
         while (got_n < 13 && n < 5000) begin @(posedge clk); n++; end
         #1 play = 1'b0;
         check(got_n >= 13, (s > 5) ? "R5" : "R4", "pulses seen at speed", got_n, 13);
         compare(s, 13, (s > 5) ? "R5" : "R4");
      end
   endtask

   task automatic t_full(input int len, input int seed, input int s, input string req);
      int n_end;
      build_image(len, seed);
      start_run(s);
      wait_done(req);
      n_end = got_n;
      check(got_n == exp_n, req, "pulse count for image", got_n, exp_n);
      compare(s, exp_n, req);
      check(rdy_last && loaded, "R9", "ready held through last pulse, loaded kept",
            int'({rdy_last, loaded}), 3);
      repeat (40) @(posedge clk);
      @(negedge clk);
      check(got_n == n_end && !tape_bit, "R9", "no pulses after image end", got_n, n_end);
   endtask

   task automatic t_pause();
      int waits [3] = '{37, 53, 71};
      build_image(3, 7);
      start_run(3);
      for (int p = 0; p < 3; p++) begin
         logic v;
         repeat (waits[p]) @(posedge clk);
         #1 motor = 1'b0;
         repeat (2) @(posedge clk);
         @(negedge clk); v = tape_bit;
         repeat (40) @(posedge clk);
         @(negedge clk);
         check(tape_bit == v, "R10", "line held while halted", int'(tape_bit), int'(v));
         @(posedge clk); #1 motor = 1'b1;
      end
      wait_done("R10");
      check(got_n == exp_n, "R10", "pulse count across pauses", got_n, exp_n);
      compare(3, exp_n, "R10");
   endtask

   task automatic t_reload();
      build_image(3, 2);
      start_run(5);
      repeat (200) @(posedge clk);
      #1 motor = 1'b0;
      @(negedge clk);
      check(got_n > 0, "R11", "progress before reload", got_n, 1);
      pulse_load();
      @(posedge clk); #1 motor = 1'b1;
      wait_done("R11");
      check(got_n == exp_n, "R11", "pulse count after restart", got_n, exp_n);
      compare(5, exp_n, "R11");
   endtask

   initial begin
      t_reset();
      t_gate();
      t_speeds();
      t_full(3, 5, 5, "R6");
      t_full(258, 9, 4, "R7");
      t_full(0, 3, 5, "R8");
      t_pause();
      t_reload();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule